// File: doc/BRIEF.md
# SCSI Initiator Phase Sequencer

This block sits behind the register interface of a SCSI host adapter. After a command is forwarded to it, the block runs the initiator side of that command and ends it in a fixed pattern of phase, interrupt-cause and sequence-step codes. The commands it handles are select with attention, select with attention and stop, transfer information, command-complete and message-accepted. It checks that the addressed target exists, hands the command to a target model over a valid/ready handshake, and raises the interrupt line. The interrupt line stays high until software acknowledges it.

The target model answers the handshake with a signed byte count: a positive count means data flows to the initiator and a negative count means data flows to the target. Later it sends a done pulse that carries the status byte of the finished command. The block holds the remaining byte count and works out the length of each transfer-information step. A memory-side engine reports the end of each DMA step on a pulse input. Bus timing and arbitration are outside this block.

Top module: `scsi_phase_seq`

## Requirements
- R1: After reset the status, interrupt-cause, sequence-step, FIFO-flags and count registers read 0, irq is low and no target request is pending.
- R2: A select command (0x42 or 0x43) aimed at an ID with no device sets status 0x80, interrupt-cause 0x20 and step 0, and raises irq one cycle after the command. IDs 0 to 6 can hold devices and ID 7 belongs to the host. A device is present when bit `id` of `present_mask` is set.
- R3: Select with attention (0x42) to a present target raises `tgt_req_valid` one cycle later, carrying the ID and a LUN. The LUN is `cmd_ident_lun` in DMA mode and is forced to 0 in PIO mode. The request holds until `tgt_req_ready`. One cycle after the handshake, a nonzero length sets interrupt-cause 0x18, step 4 and irq. Status becomes 0x91 if the length is positive (data in) or 0x90 if it is negative (data out). A zero length leaves status unchanged.
- R4: Select with attention and stop (0x43) to a present target sends no target request. One cycle later it sets status 0x92, interrupt-cause 0x18, step 4 and irq, and leaves the command bytes pending.
- R5: Transfer information (0x10) drives `xfer_len` one cycle later. A programmed count of 0 counts as 65536. While command bytes are pending, `xfer_len` is the smaller of the count and 32, and the command is then issued to the target as in R3. Otherwise `xfer_len` is the smaller of the count and the magnitude of the remaining byte count.
- R6: A `dma_done` pulse during a DMA transfer ORs 0x90 into status, sets interrupt-cause 0x10, and clears step, FIFO flags and the count register, with irq raised one cycle later.
- R7: Command-complete (0x11) puts the last target status byte on `resp_status`. In DMA mode it also sets status 0x93, interrupt-cause 0x18 and step 4. In PIO mode it sets the FIFO flags to 2 instead. In both modes irq is raised one cycle later.
- R8: Message-accepted (0x12) returns the response as in R7 and ends with interrupt-cause 0x20 and step 0.
- R9: A `tgt_done` pulse stores `tgt_status`, sets status 0x93, interrupt-cause 0x10 and step 0, clears the count and ends the active command.
- R10: A select command issued while a command is still active pulses `tgt_cancel` for one cycle, one cycle after the select.
- R11: An `intr_ack` pulse clears status bits 7, 6 and 5 and drops irq one cycle later.
- R12: A command with the DMA flag set loads the count register from `count_in`. A DMA transfer-information command with no command bytes pending clears status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 7 | Command opcode |
| cmd_dma | input | 1 | DMA flag of the command |
| cmd_ident_lun | input | 3 | LUN bits of the identify byte (DMA mode) |
| tgt_sel | input | 3 | Destination target ID |
| count_in | input | 16 | Programmed transfer count |
| present_mask | input | 7 | One bit per device ID 0 to 6 |
| intr_ack | input | 1 | Interrupt acknowledge pulse |
| dma_done | input | 1 | DMA step finished pulse |
| tgt_req_valid | output | 1 | Command request to target model |
| tgt_req_ready | input | 1 | Target accepts the request |
| tgt_req_id | output | 3 | ID of the requested target |
| tgt_req_lun | output | 3 | LUN of the request |
| tgt_len | input | 17 | Signed data length returned on acceptance |
| tgt_cancel | output | 1 | Cancel pulse for the outstanding command |
| tgt_done | input | 1 | Target command completion pulse |
| tgt_status | input | 8 | Status byte returned with `tgt_done` |
| stat_q | output | 8 | Status register |
| intr_q | output | 8 | Interrupt-cause register |
| seq_q | output | 3 | Sequence-step register |
| fifo_flags | output | 5 | FIFO-flags register |
| count_q | output | 16 | Transfer count register |
| xfer_len | output | 17 | Length of the current transfer step |
| resp_status | output | 8 | Status byte returned by the response commands |
| irq | output | 1 | Interrupt request |

## Verification
Every command, acknowledge, `dma_done` and `tgt_done` result appears one clock after the edge that samples it. The target request appears one clock after a select or a pending-command transfer, and the phase codes appear one clock after the edge that completes the handshake. The bench drives inputs just after the rising edge. Each driver task pushes its expected values, tagged with their due cycle, into a queue. A monitor on the falling edge pops every item that is due and compares it, and it reports any item whose cycle has passed as a miss.

// File: rtl/scsi_seq_pkg.sv
// Shared constants and types for the initiator phase sequencer.
// Assumes 8-bit status and interrupt registers and a 3-bit step register.
package scsi_seq_pkg;

    localparam int SEQ_W = 3;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_REQ  = 1'b1
    } seq_state_t;

    // Opcodes (without the DMA flag)
    localparam logic [6:0] OP_XFER    = 7'h10;
    localparam logic [6:0] OP_CMPL    = 7'h11;
    localparam logic [6:0] OP_MSGOK   = 7'h12;
    localparam logic [6:0] OP_SEL     = 7'h42;
    localparam logic [6:0] OP_SELSTOP = 7'h43;

    // Status register bits and phase codes
    localparam logic [7:0] ST_INT    = 8'h80;
    localparam logic [7:0] ST_TC     = 8'h10;
    localparam logic [7:0] ST_ACKCLR = 8'hE0;
    localparam logic [7:0] PH_DIN    = 8'h01;
    localparam logic [7:0] PH_CMD    = 8'h02;
    localparam logic [7:0] PH_STAT   = 8'h03;

    // Interrupt-cause codes
    localparam logic [7:0] IC_DISC  = 8'h20;
    localparam logic [7:0] IC_BSFC  = 8'h18;
    localparam logic [7:0] IC_BS    = 8'h10;

    // Sequence-step codes
    localparam logic [SEQ_W-1:0] STEP_NONE = 3'd0;
    localparam logic [SEQ_W-1:0] STEP_CMD  = 3'd4;

endpackage

// File: rtl/scsi_tgt_check.sv
// Target presence check: decides whether an ID holds a device.
// Assumes IDs at or above NUM_DEVS (the host's own ID) never hold one.
module scsi_tgt_check #(
    parameter int ID_W     = 3,
    parameter int NUM_DEVS = 7
) (
    input  logic [ID_W-1:0]     id_i,
    input  logic [NUM_DEVS-1:0] mask_i,
    output logic                present_o
);

    logic [NUM_DEVS-1:0] hit;

    // One comparator per device slot
    for (genvar i = 0; i < NUM_DEVS; i++) begin : g_slot
        assign hit[i] = mask_i[i] && (id_i == ID_W'(i));
    end

    // Present when any slot matches
    assign present_o = |hit;

endmodule

// File: rtl/scsi_xfer_len.sv
// Transfer-step length: zero count means full range; capped while command
// bytes are pending, otherwise bounded by the remaining signed byte count.
module scsi_xfer_len #(
    parameter int COUNT_W = 16,
    parameter int CMD_CAP = 32,
    localparam int LEN_W  = COUNT_W + 1
) (
    input  logic [COUNT_W-1:0] count_i,
    input  logic [LEN_W-1:0]   rem_i,
    input  logic               cmd_pend_i,
    output logic [LEN_W-1:0]   len_o
);

    localparam logic [LEN_W-1:0] FULL = {1'b1, {COUNT_W{1'b0}}};
    localparam logic [LEN_W-1:0] CAPV = LEN_W'(CMD_CAP);

    logic [LEN_W-1:0] eff;
    logic [LEN_W-1:0] mag;

    // Pick the effective count, the remaining magnitude and the minimum
    always_comb begin
        eff = (count_i == '0) ? FULL : {1'b0, count_i};
        mag = rem_i[LEN_W-1] ? (~rem_i + 1'b1) : rem_i;
        if (cmd_pend_i)
            len_o = (eff < CAPV) ? eff : CAPV;
        else
            len_o = (eff < mag) ? eff : mag;
    end

    // Command-byte steps never exceed the cap
    always_comb begin
        if (cmd_pend_i)
            assert_len_cap_R5: assert (len_o <= CAPV);
    end

endmodule

// File: rtl/scsi_phase_seq.sv
// Initiator phase sequencer top. Takes one command per strobe while idle,
// checks the target, runs the valid/ready exchange with the target model and
// loads status, interrupt-cause and step codes, raising irq.
// Assumes commands arriving while a target request is pending are dropped,
// and one-cycle pulses on dma_done and tgt_done.
module scsi_phase_seq #(
    parameter int ID_W    = 3,
    parameter int HOST_ID = 7,
    parameter int COUNT_W = 16,
    parameter int CMD_CAP = 32,
    parameter int FIFO_W  = 5,
    localparam int NUM_DEVS = HOST_ID,
    localparam int LEN_W    = COUNT_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [6:0]          cmd_code,
    input  logic                cmd_dma,
    input  logic [2:0]          cmd_ident_lun,
    input  logic [ID_W-1:0]     tgt_sel,
    input  logic [COUNT_W-1:0]  count_in,
    input  logic [NUM_DEVS-1:0] present_mask,
    input  logic                intr_ack,
    input  logic                dma_done,
    output logic                tgt_req_valid,
    input  logic                tgt_req_ready,
    output logic [ID_W-1:0]     tgt_req_id,
    output logic [2:0]          tgt_req_lun,
    input  logic [LEN_W-1:0]    tgt_len,
    output logic                tgt_cancel,
    input  logic                tgt_done,
    input  logic [7:0]          tgt_status,
    output logic [7:0]          stat_q,
    output logic [7:0]          intr_q,
    output logic [2:0]          seq_q,
    output logic [FIFO_W-1:0]   fifo_flags,
    output logic [COUNT_W-1:0]  count_q,
    output logic [LEN_W-1:0]    xfer_len,
    output logic [7:0]          resp_status,
    output logic                irq
);
    import scsi_seq_pkg::*;

    seq_state_t       st_q;
    logic             active_q;
    logic             pend_q;
    logic             busy_q;
    logic [ID_W-1:0]  id_q;
    logic [2:0]       lun_q;
    logic [LEN_W-1:0] rem_q;
    logic [7:0]       sense_q;
    logic             cancel_q;
    logic             present;
    logic [LEN_W-1:0] len_w;
    logic             accept;
    logic             is_sel;

    scsi_tgt_check #(.ID_W(ID_W), .NUM_DEVS(NUM_DEVS)) u_chk (
        .id_i      (tgt_sel),
        .mask_i    (present_mask),
        .present_o (present)
    );

    scsi_xfer_len #(.COUNT_W(COUNT_W), .CMD_CAP(CMD_CAP)) u_len (
        .count_i    (count_in),
        .rem_i      (rem_q),
        .cmd_pend_i (pend_q),
        .len_o      (len_w)
    );

    // Command acceptance decode
    assign accept = cmd_valid && (st_q == S_IDLE);
    assign is_sel = (cmd_code == OP_SEL) || (cmd_code == OP_SELSTOP);

    // Target-side outputs
    assign tgt_req_valid = (st_q == S_REQ);
    assign tgt_req_id    = id_q;
    assign tgt_req_lun   = lun_q;
    assign tgt_cancel    = cancel_q;

    // Sequencer state and register file; later events take priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= S_IDLE;
            active_q    <= 1'b0;
            pend_q      <= 1'b0;
            busy_q      <= 1'b0;
            id_q        <= '0;
            lun_q       <= '0;
            rem_q       <= '0;
            sense_q     <= '0;
            cancel_q    <= 1'b0;
            stat_q      <= '0;
            intr_q      <= '0;
            seq_q       <= '0;
            fifo_flags  <= '0;
            count_q     <= '0;
            xfer_len    <= '0;
            resp_status <= '0;
            irq         <= 1'b0;
        end else begin
            cancel_q <= 1'b0;

            if (intr_ack) begin
                stat_q <= stat_q & ~ST_ACKCLR;
                irq    <= 1'b0;
            end

            if (accept) begin
                if (cmd_dma)
                    count_q <= count_in;
                if (is_sel) begin
                    cancel_q <= active_q;
                    busy_q   <= 1'b0;
                    if (!present) begin
                        stat_q   <= ST_INT;
                        intr_q   <= IC_DISC;
                        seq_q    <= STEP_NONE;
                        irq      <= 1'b1;
                        active_q <= 1'b0;
                        pend_q   <= 1'b0;
                    end else begin
                        id_q     <= tgt_sel;
                        lun_q    <= cmd_dma ? cmd_ident_lun : 3'd0;
                        active_q <= 1'b1;
                        if (cmd_code == OP_SEL) begin
                            st_q <= S_REQ;
                        end else begin
                            stat_q <= ST_INT | ST_TC | PH_CMD;
                            intr_q <= IC_BSFC;
                            seq_q  <= STEP_CMD;
                            irq    <= 1'b1;
                            pend_q <= 1'b1;
                        end
                    end
                end else if (cmd_code == OP_XFER) begin
                    xfer_len <= len_w;
                    if (pend_q) begin
                        pend_q <= 1'b0;
                        st_q   <= S_REQ;
                    end else if (cmd_dma) begin
                        stat_q <= stat_q & ~ST_TC;
                        busy_q <= 1'b1;
                    end
                end else if (cmd_code == OP_CMPL || cmd_code == OP_MSGOK) begin
                    resp_status <= sense_q;
                    irq         <= 1'b1;
                    if (cmd_dma) begin
                        stat_q <= ST_INT | ST_TC | PH_STAT;
                        intr_q <= IC_BSFC;
                        seq_q  <= STEP_CMD;
                    end else begin
                        fifo_flags <= FIFO_W'(2);
                    end
                    if (cmd_code == OP_MSGOK) begin
                        intr_q <= IC_DISC;
                        seq_q  <= STEP_NONE;
                    end
                end
            end

            if ((st_q == S_REQ) && tgt_req_ready) begin
                st_q  <= S_IDLE;
                rem_q <= tgt_len;
                if (tgt_len != '0)
                    stat_q <= ST_INT | ST_TC | (tgt_len[LEN_W-1] ? 8'h00 : PH_DIN);
                intr_q <= IC_BSFC;
                seq_q  <= STEP_CMD;
                irq    <= 1'b1;
            end

            if (dma_done && busy_q) begin
                busy_q     <= 1'b0;
                rem_q      <= rem_q[LEN_W-1] ? (rem_q + xfer_len) : (rem_q - xfer_len);
                stat_q     <= stat_q | ST_INT | ST_TC;
                intr_q     <= IC_BS;
                seq_q      <= STEP_NONE;
                fifo_flags <= '0;
                count_q    <= '0;
                irq        <= 1'b1;
            end

            if (tgt_done) begin
                sense_q    <= tgt_status;
                stat_q     <= ST_INT | ST_TC | PH_STAT;
                intr_q     <= IC_BS;
                seq_q      <= STEP_NONE;
                fifo_flags <= '0;
                count_q    <= '0;
                irq        <= 1'b1;
                active_q   <= 1'b0;
                busy_q     <= 1'b0;
                rem_q      <= '0;
            end
        end
    end

    // Absent target ends in an immediate disconnect
    assert_absent_disc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_sel && !present && !tgt_done && !dma_done)
        |=> (intr_q == IC_DISC && seq_q == STEP_NONE && irq && stat_q == ST_INT));

    // Target request is held until accepted
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req_valid && !tgt_req_ready) |=> tgt_req_valid);

    // Select-and-stop never asks the target for anything
    assert_stop_noreq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_code == OP_SELSTOP) |=> !tgt_req_valid);

    // Target completion always lands in the bus-service/step-0 codes
    assert_done_codes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_done |=> (intr_q == IC_BS && seq_q == STEP_NONE && irq && count_q == '0));

    // Cancel only follows a select
    assert_cancel_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_cancel |-> $past(accept && is_sel));

    // Step register only ever holds one of two codes
    always_comb begin
        if (rst_n)
            assert_step_code_R3: assert (seq_q == STEP_NONE || seq_q == STEP_CMD);
    end

endmodule

// File: tb/scsi_phase_seq_test.sv
// Scoreboard bench: driver tasks push due-cycle expectations, a falling-edge
// monitor pops and compares them.
module scsi_phase_seq_test;

    localparam int SEL_STAT = 0, SEL_INTR = 1, SEL_SEQ = 2, SEL_IRQ = 3,
                   SEL_FIFO = 4, SEL_CNT = 5, SEL_LEN = 6, SEL_REQ = 7,
                   SEL_RID = 8, SEL_LUN = 9, SEL_CAN = 10, SEL_RESP = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [6:0]  cmd_code = '0;
    logic        cmd_dma = 1'b0;
    logic [2:0]  cmd_ident_lun = '0;
    logic [2:0]  tgt_sel = '0;
    logic [15:0] count_in = '0;
    logic [6:0]  present_mask = 7'b0001011;
    logic        intr_ack = 1'b0;
    logic        dma_done = 1'b0;
    logic        tgt_req_valid;
    logic        tgt_req_ready = 1'b0;
    logic [2:0]  tgt_req_id;
    logic [2:0]  tgt_req_lun;
    logic [16:0] tgt_len = '0;
    logic        tgt_cancel;
    logic        tgt_done = 1'b0;
    logic [7:0]  tgt_status = '0;
    logic [7:0]  stat_q;
    logic [7:0]  intr_q;
    logic [2:0]  seq_q;
    logic [4:0]  fifo_flags;
    logic [15:0] count_q;
    logic [16:0] xfer_len;
    logic [7:0]  resp_status;
    logic        irq;

    scsi_phase_seq uut (
        .clk, .rst_n, .cmd_valid, .cmd_code, .cmd_dma, .cmd_ident_lun,
        .tgt_sel, .count_in, .present_mask, .intr_ack, .dma_done,
        .tgt_req_valid, .tgt_req_ready, .tgt_req_id, .tgt_req_lun, .tgt_len,
        .tgt_cancel, .tgt_done, .tgt_status, .stat_q, .intr_q, .seq_q,
        .fifo_flags, .count_q, .xfer_len, .resp_status, .irq
    );

    always #2 clk = ~clk;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        string       rq;
        int          sel;
        logic [31:0] val;
        int          due;
    } exp_t;

    exp_t sb[$];

    function automatic logic [31:0] actual(input int sel);
        case (sel)
            SEL_STAT: return 32'(stat_q);
            SEL_INTR: return 32'(intr_q);
            SEL_SEQ:  return 32'(seq_q);
            SEL_IRQ:  return 32'(irq);
            SEL_FIFO: return 32'(fifo_flags);
            SEL_CNT:  return 32'(count_q);
            SEL_LEN:  return 32'(xfer_len);
            SEL_REQ:  return 32'(tgt_req_valid);
            SEL_RID:  return 32'(tgt_req_id);
            SEL_LUN:  return 32'(tgt_req_lun);
            SEL_CAN:  return 32'(tgt_cancel);
            default:  return 32'(resp_status);
        endcase
    endfunction

    // Push an expectation due in the current cycle
    task automatic expect_now(input string rq, input int sel, input logic [31:0] v);
        exp_t e;
        e.rq = rq; e.sel = sel; e.val = v; e.due = cyc;
        sb.push_back(e);
    endtask

    // Monitor: compare every due item on the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            logic [31:0] a;
            e = sb.pop_front();
            a = actual(e.sel);
            checks++;
            if (e.due < cyc || a !== e.val) begin
                fails++;
                $display("FAIL %s output %0d actual %h expected %h", e.rq, e.sel, a, e.val);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic [6:0] code, input logic dma, input logic [2:0] id,
                         input logic [2:0] lun, input logic [15:0] cnt);
        step();
        cmd_valid = 1'b1; cmd_code = code; cmd_dma = dma;
        tgt_sel = id; cmd_ident_lun = lun; count_in = cnt;
        step();
        cmd_valid = 1'b0;
    endtask

    task automatic respond(input logic [16:0] len);
        step();
        tgt_req_ready = 1'b1; tgt_len = len;
        step();
        tgt_req_ready = 1'b0;
    endtask

    task automatic ack(input logic [7:0] stat_after);
        step();
        intr_ack = 1'b1;
        step();
        intr_ack = 1'b0;
        expect_now("R11 ack status", SEL_STAT, 32'(stat_after));
        expect_now("R11 ack irq", SEL_IRQ, 0);
    endtask

    task automatic codes(input string rq, input logic [7:0] s, input logic [7:0] i,
                         input logic [2:0] q);
        expect_now(rq, SEL_STAT, 32'(s));
        expect_now(rq, SEL_INTR, 32'(i));
        expect_now(rq, SEL_SEQ, 32'(q));
        expect_now(rq, SEL_IRQ, 1);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        expect_now("R1 stat", SEL_STAT, 0);
        expect_now("R1 intr", SEL_INTR, 0);
        expect_now("R1 seq", SEL_SEQ, 0);
        expect_now("R1 irq", SEL_IRQ, 0);
        expect_now("R1 fifo", SEL_FIFO, 0);
        expect_now("R1 count", SEL_CNT, 0);
        expect_now("R1 req", SEL_REQ, 0);

        // R2 absent ID 2 and host ID 7
        issue(7'h42, 1'b0, 3'd2, 3'd0, 16'd0);
        codes("R2 absent id2", 8'h80, 8'h20, 3'd0);
        ack(8'h00);
        issue(7'h43, 1'b0, 3'd7, 3'd0, 16'd0);
        codes("R2 host id7", 8'h80, 8'h20, 3'd0);
        expect_now("R2 no request", SEL_REQ, 0);
        ack(8'h00);

        // R3 select ID 1 in DMA mode, LUN 5; R12 count load
        issue(7'h42, 1'b1, 3'd1, 3'd5, 16'h0040);
        expect_now("R3 req valid", SEL_REQ, 1);
        expect_now("R3 req id", SEL_RID, 1);
        expect_now("R3 dma lun", SEL_LUN, 5);
        expect_now("R12 count load", SEL_CNT, 32'h40);
        expect_now("R10 no cancel", SEL_CAN, 0);
        step();
        expect_now("R3 req held", SEL_REQ, 1);
        respond(17'd100);
        codes("R3 data in", 8'h91, 8'h18, 3'd4);
        expect_now("R3 req dropped", SEL_REQ, 0);
        ack(8'h11);

        // R5 / R12 DMA transfer of min(64,100)
        issue(7'h10, 1'b1, 3'd1, 3'd0, 16'h0040);
        expect_now("R5 min count", SEL_LEN, 64);
        expect_now("R12 tc cleared", SEL_STAT, 32'h01);
        // R6 DMA completion
        step();
        dma_done = 1'b1;
        step();
        dma_done = 1'b0;
        codes("R6 dma done", 8'h91, 8'h10, 3'd0);
        expect_now("R6 fifo", SEL_FIFO, 0);
        expect_now("R6 count", SEL_CNT, 0);
        ack(8'h11);

        // R5 zero count = 65536, bounded by remaining 36; PIO keeps count
        issue(7'h10, 1'b0, 3'd1, 3'd0, 16'd0);
        expect_now("R5 zero count", SEL_LEN, 36);
        expect_now("R12 pio no load", SEL_CNT, 0);
        expect_now("R5 pio stat", SEL_STAT, 32'h11);

        // R10 cancel on reselect; R3 PIO lun forced 0
        issue(7'h42, 1'b0, 3'd0, 3'd7, 16'd0);
        expect_now("R10 cancel", SEL_CAN, 1);
        expect_now("R3 pio lun", SEL_LUN, 0);
        expect_now("R3 req id0", SEL_RID, 0);
        step();
        expect_now("R10 cancel one cycle", SEL_CAN, 0);
        respond(-17'sd20);
        codes("R3 data out", 8'h90, 8'h18, 3'd4);
        ack(8'h10);
        issue(7'h10, 1'b0, 3'd0, 3'd0, 16'd0);
        expect_now("R5 negative remaining", SEL_LEN, 20);

        // R9 completion from target
        step();
        tgt_done = 1'b1; tgt_status = 8'h02;
        step();
        tgt_done = 1'b0;
        codes("R9 target done", 8'h93, 8'h10, 3'd0);
        ack(8'h13);

        // R7 command-complete, DMA then PIO
        issue(7'h11, 1'b1, 3'd0, 3'd0, 16'd0);
        codes("R7 dma", 8'h93, 8'h18, 3'd4);
        expect_now("R7 resp", SEL_RESP, 2);
        ack(8'h13);
        issue(7'h11, 1'b0, 3'd0, 3'd0, 16'd0);
        expect_now("R7 pio fifo", SEL_FIFO, 2);
        expect_now("R7 pio resp", SEL_RESP, 2);
        expect_now("R7 pio irq", SEL_IRQ, 1);
        ack(8'h13);

        // R8 message accepted
        issue(7'h12, 1'b0, 3'd0, 3'd0, 16'd0);
        expect_now("R8 intr", SEL_INTR, 32'h20);
        expect_now("R8 seq", SEL_SEQ, 0);
        expect_now("R8 irq", SEL_IRQ, 1);
        ack(8'h13);

        // R4 select and stop to ID 3, LUN 2
        issue(7'h43, 1'b1, 3'd3, 3'd2, 16'd0);
        codes("R4 stop", 8'h92, 8'h18, 3'd4);
        expect_now("R4 no request", SEL_REQ, 0);
        ack(8'h12);

        // R5 pending command bytes capped at 32, then issued
        issue(7'h10, 1'b0, 3'd3, 3'd0, 16'h0100);
        expect_now("R5 cap 32", SEL_LEN, 32);
        expect_now("R5 issue req", SEL_REQ, 1);
        expect_now("R5 lun kept", SEL_LUN, 2);
        expect_now("R5 id kept", SEL_RID, 3);
        respond(17'd8);
        codes("R5 command sent", 8'h91, 8'h18, 3'd4);

        repeat (4) step();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule